// File: doc/BRIEF.md
# Panel Power-Up Command Sequencer

This block takes a grayscale LCD controller from reset to a lit display. It first holds the panel's active-low reset line low for a set time. After a recovery wait it issues a fixed script of 8-bit command and parameter bytes on a byte valid/ready interface. A flag beside each byte tells the serial shifter downstream how to drive the data/command line. Millisecond waits sit at fixed points in the script. They are timed by a delay counter that uses a clocks-per-millisecond parameter.

A 2-bit rotation input picks the parameter byte that follows the address-mode command. Before the final display-on command the sequencer pauses. It raises a flush request so that an external window-update stage can write a full frame, and it resumes only when that stage reports completion. After display-on is accepted the sequencer raises a done status and sends nothing more. No data is ever read back from the panel.

Top module: `panel_init_seq`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `flush_req` and `init_done` are 0 and `panel_rst_n` is 0 (panel held in reset).
- R2: After `rst_n` is released, `panel_rst_n` stays low for about RESET_MS x CLKS_PER_MS clocks, then rises. The first byte is accepted no sooner than RECOVER_MS x CLKS_PER_MS clocks after the rise. No byte is offered while `panel_rst_n` is low.
- R3: The accepted bytes follow this exact order (C = command, P = parameter): C D7, P 9F, C E0, P 00, C E3, C E1, C 11, C 28, C C7, P 00, C C0, P E3, P 00, C C3, P 02, C C4, P 04, C D0, P 1D, C B5, P 00, C 38, C 3A, P 02, C 36, P rotation byte, C B0, P 7F, C B4, P A0, C 30, P 00, P 00, P 00, P 77, C 20, C 29. There are 37 bytes in all.
- R4: The gap before C E3 is at least 10 ms. The gap before C E1 is at least 20 ms. The gap before C C7 is at least 50 ms. The gap between C 20 and the flush request is at least 100 ms. One ms is CLKS_PER_MS clocks. With `out_ready` held high, each of these waits adds no more than 4 clocks of overhead beyond its nominal length.
- R5: The parameter byte after C 36 follows `rot`: 0 gives 0x00, 1 (90 degrees) gives 0x80, 2 (180 degrees) gives 0xC0, and 3 (270 degrees) gives 0x40.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_dc` hold their values. Each byte is transferred exactly once, on a cycle where both are high.
- R7: After the 100 ms wait, `flush_req` goes high and stays high until `flush_done` is seen. No byte is offered while `flush_req` is high. C 29 is offered only after the flush completes.
- R8: A `flush_done` pulse that arrives while `flush_req` is low has no effect. The sequencer still raises `flush_req` later and waits for a fresh `flush_done`.
- R9: Once C 29 has been accepted, `init_done` goes high and stays high, and `out_valid` stays low.
- R10: `out_dc` is 0 for command bytes and 1 for parameter bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rot | input | 2 | Rotation select: 0, 90, 180, 270 degrees |
| out_byte | output | 8 | Byte to the serial shifter |
| out_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Shifter accepts the byte |
| panel_rst_n | output | 1 | Active-low panel reset |
| flush_req | output | 1 | Request for a full-frame window update |
| flush_done | input | 1 | Window update finished |
| init_done | output | 1 | Panel is initialised and on |

## Verification
Two events can fall in the same cycle. One is a `flush_done` pulse from the update stage. The other is the delay timer reaching the end of the 100 ms wait that leads into the flush point. The bench provokes this by pulsing `flush_done` during that wait, before any request has been made. It then judges that `flush_req` still rises afterwards and is held, with no byte offered, until a second `flush_done` arrives. A further run holds `out_ready` low on a repeating pattern. This checks that every stalled byte stays put and that the script still comes out complete and in order.

// File: rtl/panel_init_pkg.sv
// Shared types for the panel power-up sequencer.
// Assumes: script fits in 64 steps; wait values are whole milliseconds.
package panel_init_pkg;

    typedef enum logic [2:0] {
        K_CMD   = 3'd0,   // command byte, dc low
        K_PAR   = 3'd1,   // parameter byte, dc high
        K_WAIT  = 3'd2,   // delay, val = milliseconds
        K_RST   = 3'd3,   // panel reset low, val = milliseconds
        K_FLUSH = 3'd4,   // hand off to the window-update stage
        K_END   = 3'd5    // script finished
    } step_kind_t;

    typedef struct packed {
        step_kind_t kind;
        logic [7:0] val;
    } step_t;

    localparam int N_STEPS = 45;
    localparam int IDX_W   = $clog2(N_STEPS);

    function automatic step_t mk(step_kind_t k, logic [7:0] v);
        step_t s;
        s.kind = k;
        s.val  = v;
        return s;
    endfunction

    // Address-mode parameter for each rotation: row mirror is bit 7, column mirror bit 6
    function automatic logic [7:0] rot_param(logic [1:0] r);
        case (r)
            2'd1:    return 8'h80;
            2'd2:    return 8'hC0;
            2'd3:    return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pinit_ms_timer.sv
// Millisecond delay timer.
// What: on start, counts ms x CLKS_PER_MS clocks and then pulses done for one cycle.
// Assumes: start is not raised while busy; ms = 0 gives done on the next cycle.
module pinit_ms_timer #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms,
    output logic            busy,
    output logic            done
);
    localparam int PW = $clog2(CLKS_PER_MS + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0]   pre;
    logic [MS_W-1:0] ms_left;

    // Prescale clocks into milliseconds and count the milliseconds down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            pre     <= '0;
            ms_left <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (ms == '0) begin
                    done <= 1'b1;
                end else begin
                    busy    <= 1'b1;
                    ms_left <= ms;
                    pre     <= PRE_TOP;
                end
            end else if (busy) begin
                if (pre == '0) begin
                    pre <= PRE_TOP;
                    if (ms_left == MS_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        ms_left <= ms_left - 1'b1;
                    end
                end else begin
                    pre <= pre - 1'b1;
                end
            end
        end
    end

    // R4
    tmr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pinit_script.sv
// Init script store.
// What: maps a step index to a step (kind and byte or ms value); the rotation input picks the address-mode parameter.
// Assumes: indices past the last step read as K_END.
module pinit_script
    import panel_init_pkg::*;
#(
    parameter int RESET_MS   = 10,
    parameter int RECOVER_MS = 120
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       rot,
    output step_t            step
);
    // Decode the step at idx
    always_comb begin
        case (idx)
            6'd0:  step = mk(K_RST,  8'(RESET_MS));
            6'd1:  step = mk(K_WAIT, 8'(RECOVER_MS));
            6'd2:  step = mk(K_CMD,  8'hD7);
            6'd3:  step = mk(K_PAR,  8'h9F);
            6'd4:  step = mk(K_CMD,  8'hE0);
            6'd5:  step = mk(K_PAR,  8'h00);
            6'd6:  step = mk(K_WAIT, 8'd10);
            6'd7:  step = mk(K_CMD,  8'hE3);
            6'd8:  step = mk(K_WAIT, 8'd20);
            6'd9:  step = mk(K_CMD,  8'hE1);
            6'd10: step = mk(K_CMD,  8'h11);
            6'd11: step = mk(K_CMD,  8'h28);
            6'd12: step = mk(K_WAIT, 8'd50);
            6'd13: step = mk(K_CMD,  8'hC7);
            6'd14: step = mk(K_PAR,  8'h00);
            6'd15: step = mk(K_CMD,  8'hC0);
            6'd16: step = mk(K_PAR,  8'hE3);
            6'd17: step = mk(K_PAR,  8'h00);
            6'd18: step = mk(K_CMD,  8'hC3);
            6'd19: step = mk(K_PAR,  8'h02);
            6'd20: step = mk(K_CMD,  8'hC4);
            6'd21: step = mk(K_PAR,  8'h04);
            6'd22: step = mk(K_CMD,  8'hD0);
            6'd23: step = mk(K_PAR,  8'h1D);
            6'd24: step = mk(K_CMD,  8'hB5);
            6'd25: step = mk(K_PAR,  8'h00);
            6'd26: step = mk(K_CMD,  8'h38);
            6'd27: step = mk(K_CMD,  8'h3A);
            6'd28: step = mk(K_PAR,  8'h02);
            6'd29: step = mk(K_CMD,  8'h36);
            6'd30: step = mk(K_PAR,  rot_param(rot));
            6'd31: step = mk(K_CMD,  8'hB0);
            6'd32: step = mk(K_PAR,  8'h7F);
            6'd33: step = mk(K_CMD,  8'hB4);
            6'd34: step = mk(K_PAR,  8'hA0);
            6'd35: step = mk(K_CMD,  8'h30);
            6'd36: step = mk(K_PAR,  8'h00);
            6'd37: step = mk(K_PAR,  8'h00);
            6'd38: step = mk(K_PAR,  8'h00);
            6'd39: step = mk(K_PAR,  8'h77);
            6'd40: step = mk(K_CMD,  8'h20);
            6'd41: step = mk(K_WAIT, 8'd100);
            6'd42: step = mk(K_FLUSH, 8'h00);
            6'd43: step = mk(K_CMD,  8'h29);
            default: step = mk(K_END, 8'h00);
        endcase
    end

endmodule

// File: rtl/panel_init_seq.sv
// Panel power-up command sequencer (top).
// What: walks the init script. It pulses the panel reset, offers each byte on a valid/ready port, runs the timed waits, and pauses for a frame flush before display-on.
// Assumes: the downstream shifter honours valid/ready; flush_done is a pulse or level seen only while flush_req is high.
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int CLKS_PER_MS = 50000,
    parameter int RESET_MS    = 10,
    parameter int RECOVER_MS  = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rot,
    output logic [7:0] out_byte,
    output logic       out_dc,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       panel_rst_n,
    output logic       flush_req,
    input  logic       flush_done,
    output logic       init_done
);
    localparam int MS_W = 8;

    logic [IDX_W-1:0] idx;
    step_t            cur;
    logic             armed;
    logic             tmr_start;
    logic             tmr_busy;
    logic             tmr_done;
    logic             timed_step;

    pinit_script #(
        .RESET_MS   (RESET_MS),
        .RECOVER_MS (RECOVER_MS)
    ) i_script (
        .idx  (idx),
        .rot  (rot),
        .step (cur)
    );

    pinit_ms_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .MS_W        (MS_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .ms    (cur.val),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // Start the timer once on entry to a timed step
    always_comb begin
        timed_step = (cur.kind == K_WAIT) || (cur.kind == K_RST);
        tmr_start  = timed_step && !armed;
    end

    // Step through the script and drive the byte port, panel reset and flush handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx         <= '0;
            armed       <= 1'b0;
            out_valid   <= 1'b0;
            out_byte    <= 8'h00;
            out_dc      <= 1'b0;
            flush_req   <= 1'b0;
            init_done   <= 1'b0;
            panel_rst_n <= 1'b0;
        end else begin
            case (cur.kind)
                K_CMD, K_PAR: begin
                    if (!out_valid) begin
                        out_valid <= 1'b1;
                        out_byte  <= cur.val;
                        out_dc    <= (cur.kind == K_PAR);
                    end else if (out_ready) begin
                        out_valid <= 1'b0;
                        idx       <= idx + 1'b1;
                    end
                end
                K_WAIT, K_RST: begin
                    if (!armed) begin
                        armed <= 1'b1;
                        if (cur.kind == K_RST) panel_rst_n <= 1'b0;
                    end else if (tmr_done) begin
                        armed <= 1'b0;
                        idx   <= idx + 1'b1;
                        if (cur.kind == K_RST) panel_rst_n <= 1'b1;
                    end
                end
                K_FLUSH: begin
                    if (!flush_req) begin
                        flush_req <= 1'b1;
                    end else if (flush_done) begin
                        flush_req <= 1'b0;
                        idx       <= idx + 1'b1;
                    end
                end
                default: begin
                    init_done <= 1'b1;
                end
            endcase
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_dc));

    // R7
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_done |=> flush_req);

    // R7
    no_byte_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !out_valid);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done && !out_valid);

    // R2
    quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !out_valid);

    // R4
    tmr_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> !tmr_busy);

endmodule

// File: tb/test_panel_init_seq.sv
`timescale 1ns/100ps
module test_panel_init_seq;
    localparam int CPM = 20;
    localparam int RMS = 2;
    localparam int QMS = 3;
    localparam int NB  = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rot = 2'd0;
    logic [7:0] out_byte;
    logic       out_dc;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       panel_rst_n;
    logic       flush_req;
    logic       flush_done = 1'b0;
    logic       init_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] cap_byte [64];
    logic       cap_dc   [64];
    int         cap_t    [64];
    int         cap_n;
    int         stab_bad, flush_bad, after_bad, rst_bad;
    int         prst_low, rise_t, flush_rise_t;
    logic       prev_stall;
    logic [7:0] prev_byte;
    logic       prev_dc;
    logic       mon_en = 1'b0;
    logic       stall_mode = 1'b0;

    always #2.5 clk = ~clk;

    panel_init_seq #(
        .CLKS_PER_MS (CPM),
        .RESET_MS    (RMS),
        .RECOVER_MS  (QMS)
    ) i_panel_init_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rot         (rot),
        .out_byte    (out_byte),
        .out_dc      (out_dc),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .panel_rst_n (panel_rst_n),
        .flush_req   (flush_req),
        .flush_done  (flush_done),
        .init_done   (init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected byte list {dc, byte} from R3, R5 and R10
    function automatic logic [8:0] exp_byte(int i, logic [1:0] r);
        logic [7:0] rb;
        case (r)
            2'd1: rb = 8'h80;
            2'd2: rb = 8'hC0;
            2'd3: rb = 8'h40;
            default: rb = 8'h00;
        endcase
        case (i)
            0: return {1'b0, 8'hD7};  1: return {1'b1, 8'h9F};
            2: return {1'b0, 8'hE0};  3: return {1'b1, 8'h00};
            4: return {1'b0, 8'hE3};  5: return {1'b0, 8'hE1};
            6: return {1'b0, 8'h11};  7: return {1'b0, 8'h28};
            8: return {1'b0, 8'hC7};  9: return {1'b1, 8'h00};
            10: return {1'b0, 8'hC0}; 11: return {1'b1, 8'hE3};
            12: return {1'b1, 8'h00}; 13: return {1'b0, 8'hC3};
            14: return {1'b1, 8'h02}; 15: return {1'b0, 8'hC4};
            16: return {1'b1, 8'h04}; 17: return {1'b0, 8'hD0};
            18: return {1'b1, 8'h1D}; 19: return {1'b0, 8'hB5};
            20: return {1'b1, 8'h00}; 21: return {1'b0, 8'h38};
            22: return {1'b0, 8'h3A}; 23: return {1'b1, 8'h02};
            24: return {1'b0, 8'h36}; 25: return {1'b1, rb};
            26: return {1'b0, 8'hB0}; 27: return {1'b1, 8'h7F};
            28: return {1'b0, 8'hB4}; 29: return {1'b1, 8'hA0};
            30: return {1'b0, 8'h30}; 31: return {1'b1, 8'h00};
            32: return {1'b1, 8'h00}; 33: return {1'b1, 8'h00};
            34: return {1'b1, 8'h77}; 35: return {1'b0, 8'h20};
            default: return {1'b0, 8'h29};
        endcase
    endfunction

    // Cycle count, watchdog and ready pattern
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        #1;
        if (stall_mode) out_ready = (cyc % 3 == 0);
        else            out_ready = 1'b1;
    end

    // Port monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_stall && !(out_valid && out_byte == prev_byte && out_dc == prev_dc))
                stab_bad++;
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            prev_dc    = out_dc;
            if (!panel_rst_n) begin
                prst_low++;
                if (out_valid) rst_bad++;
            end else if (rise_t < 0) begin
                rise_t = cyc;
            end
            if (flush_req && out_valid) flush_bad++;
            if (flush_req && flush_rise_t < 0) flush_rise_t = cyc;
            if (init_done && out_valid) after_bad++;
            if (out_valid && out_ready) begin
                if (cap_n < 64) begin
                    cap_byte[cap_n] = out_byte;
                    cap_dc[cap_n]   = out_dc;
                    cap_t[cap_n]    = cyc;
                end
                cap_n++;
            end
        end
    end

    task automatic do_reset();
        mon_en = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cap_n = 0; stab_bad = 0; flush_bad = 0; after_bad = 0; rst_bad = 0;
        prst_low = 0; rise_t = -1; flush_rise_t = -1; prev_stall = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    task automatic test_reset_state();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(flush_req == 1'b0 && init_done == 1'b0, "R1 flush_req/init_done", {flush_req, init_done}, 0);
        check(panel_rst_n == 1'b0, "R1 panel_rst_n", panel_rst_n, 0);
    endtask

    // One full run; early_pulse exercises R8, stall exercises R6
    task automatic run_seq(input logic [1:0] r, input bit stall, input bit early_pulse, input string tag);
        int t0;
        rot = r;
        stall_mode = stall;
        do_reset();
        t0 = cyc;
        while (cap_n < 36 && cyc - t0 < 20000) @(negedge clk);
        if (early_pulse) begin
            repeat (10) @(posedge clk);
            #1 flush_done = 1'b1;
            @(posedge clk); #1 flush_done = 1'b0;
        end
        while (!flush_req && cyc - t0 < 20000) @(negedge clk);
        check(flush_req == 1'b1, {tag, " R7 flush_req raised"}, flush_req, 1);
        repeat (30) @(negedge clk);
        check(flush_req == 1'b1 && cap_n == 36, {tag, " R7/R8 held waiting for flush_done"}, cap_n, 36);
        @(posedge clk); #1 flush_done = 1'b1;
        @(posedge clk); #1 flush_done = 1'b0;
        while (!init_done && cyc - t0 < 20000) @(negedge clk);
        repeat (20) @(negedge clk);
        mon_en = 1'b0;
        check(init_done == 1'b1, {tag, " R9 init_done"}, init_done, 1);
        check(cap_n == NB, {tag, " R3/R9 byte count"}, cap_n, NB);
        begin
            int bad = 0;
            int first = -1;
            for (int i = 0; i < NB; i++) begin
                if ({cap_dc[i], cap_byte[i]} != exp_byte(i, r)) begin
                    bad++;
                    if (first < 0) first = i;
                end
            end
            check(bad == 0, {tag, " R3/R10 byte order and dc"}, (first < 0) ? 0 : {cap_dc[first], cap_byte[first]},
                  (first < 0) ? 0 : exp_byte(first, r));
        end
        check({cap_dc[25], cap_byte[25]} == exp_byte(25, r), {tag, " R5 rotation param"}, cap_byte[25], exp_byte(25, r));
        check(stab_bad == 0, {tag, " R6 stalled byte stable"}, stab_bad, 0);
        check(flush_bad == 0 && after_bad == 0, {tag, " R7/R9 no byte during flush or after done"}, flush_bad + after_bad, 0);
        check(rst_bad == 0, {tag, " R2 no byte in panel reset"}, rst_bad, 0);
        check(prst_low >= RMS*CPM && prst_low <= RMS*CPM + 4, {tag, " R2 panel reset width"}, prst_low, RMS*CPM);
        check(cap_t[0] - rise_t >= QMS*CPM, {tag, " R2 recovery wait"}, cap_t[0] - rise_t, QMS*CPM);
        check(cap_t[4] - cap_t[3] >= 10*CPM, {tag, " R4 10 ms wait"}, cap_t[4] - cap_t[3], 10*CPM);
        check(cap_t[5] - cap_t[4] >= 20*CPM, {tag, " R4 20 ms wait"}, cap_t[5] - cap_t[4], 20*CPM);
        check(cap_t[8] - cap_t[7] >= 50*CPM, {tag, " R4 50 ms wait"}, cap_t[8] - cap_t[7], 50*CPM);
        check(flush_rise_t - cap_t[35] >= 100*CPM, {tag, " R4 100 ms wait"}, flush_rise_t - cap_t[35], 100*CPM);
        if (!stall) begin
            check(cap_t[4] - cap_t[3] <= 10*CPM + 4, {tag, " R4 10 ms upper"}, cap_t[4] - cap_t[3], 10*CPM + 4);
            check(cap_t[8] - cap_t[7] <= 50*CPM + 4, {tag, " R4 50 ms upper"}, cap_t[8] - cap_t[7], 50*CPM + 4);
            check(cap_t[1] - cap_t[0] == 2, {tag, " R6 back-to-back spacing"}, cap_t[1] - cap_t[0], 2);
        end
    endtask

    initial begin
        test_reset_state();
        run_seq(2'd0, 1'b0, 1'b0, "rot0");
        run_seq(2'd1, 1'b0, 1'b1, "rot90 early flush_done");
        run_seq(2'd2, 1'b1, 1'b0, "rot180 stalled");
        run_seq(2'd3, 1'b0, 1'b0, "rot270");
        test_reset_state();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule